// File: doc/BRIEF.md
# Multi-Cycle Load/Store Processor Core

This block is a small 32-bit load/store processor core. It takes each instruction through a fixed sequence of steps, one step per clock cycle, and uses one ALU and one memory port for every step. The steps are fetch, decode with register read, execute or address calculation, memory access or branch resolution, and register write-back. Stores, branches and unrecognised opcodes end after the memory step. Every other instruction also takes the write-back step.

The core is built into a larger design next to a single word-addressed memory that holds both program and data. The memory read is combinational within the cycle, and writes take effect at the clock edge. Program counters and byte addresses are 32-bit byte addresses. The memory word index is the byte address divided by four. The current program counter and the step number come out on debug ports so that the surrounding logic can follow execution.

Top module: `mcyc_core`

## Requirements
- R1: While reset is asserted, dbg_pc reads 0 and dbg_state reads 0. The step codes are fetch=0, decode=1, execute=2, memory=3, write-back=4.
- R2: Fetch reads the memory word at index PC/4. An instruction that is not a branch moves the PC to PC+4 at the end of its last step.
- R3: Field decoding uses these slices:
  - opcode is bits [31:26]
  - first source register is [25:20+1], that is [25:21]
  - second source or immediate destination is [20:16]
  - register-register destination is [15:11]
  - function code is [5:0]
  - the 16-bit immediate [15:0] is sign-extended, including on load and store offsets.
- R4: Opcode 0x00 is a register-register operation. Its function code selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than. The result is written to the [15:11] register.
- R5: Register-immediate operations combine the first source register with the immediate and write the result to the [20:16] register. The opcodes are 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or, 0x0E xor.
- R6: Opcode 0x23 loads the word at byte address (source + immediate) into the [20:16] register.
- R7: Opcode 0x2B writes the [20:16] register to byte address (source + immediate). The write happens during the memory step, and that is the only step in which mem_we is high.
- R8: Opcode 0x04 branches to (PC+4) + immediate when the first source register is zero. Otherwise execution continues at PC+4.
- R9: Stores, branches and undefined opcodes take 4 cycles. All other instructions take 5. The steps run in code order 0,1,2,3, then 4 where it applies.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: An undefined opcode changes no register and no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | AW (16) | Word index for the shared memory |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe, taken at the rising edge |
| mem_rdata | input | 32 | Combinational read data for mem_addr |
| dbg_pc | output | 32 | Current program counter (byte address) |
| dbg_state | output | 3 | Current step code |

## Verification
A wrong internal latch shows up as a wrong word written by the next store. A wrong operand, sign extension or destination field does the same. Each result is therefore stored to its own memory slot a few cycles after it is computed, and the bench compares all the slots at the end. A sequencer fault changes how many cycles the PC stays on one instruction, and the debug PC shows that within one instruction. A branch fault either leaves a guard slot unwritten or writes a slot that should have been skipped.

// File: rtl/mcyc_pkg.sv
`timescale 1ns/1ps
package mcyc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;

  typedef enum logic [2:0] {
    ST_IF  = 3'd0,
    ST_ID  = 3'd1,
    ST_EX  = 3'd2,
    ST_MEM = 3'd3,
    ST_WB  = 3'd4
  } step_e;

  typedef enum logic [2:0] {
    CL_RR, CL_IMM, CL_LOAD, CL_STORE, CL_BRANCH, CL_NOP
  } iclass_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_ZERO
  } alu_op_e;

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_BEQZ = 6'h04;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_SLTI = 6'h0A;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_XORI = 6'h0E;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/mcyc_decode.sv
`timescale 1ns/1ps
module mcyc_decode
  import mcyc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [31:0]  ir,
  output iclass_e      iclass,
  output alu_op_e      alu_op,
  output logic [4:0]   rs1,
  output logic [4:0]   rs2,
  output logic [4:0]   rd_rr,
  output logic [W-1:0] imm_ext
);
  logic [5:0] opcode;
  logic [5:0] func;

  assign opcode  = ir[31:26];
  assign rs1     = ir[25:21];
  assign rs2     = ir[20:16];
  assign rd_rr   = ir[15:11];
  assign func    = ir[5:0];
  assign imm_ext = {{(W-16){ir[15]}}, ir[15:0]};

  logic unused_shamt;
  assign unused_shamt = ^ir[10:6];

  always_comb begin
    iclass = CL_NOP;
    alu_op = ALU_ADD;
    case (opcode)
      OP_RR: begin
        iclass = CL_RR;
        case (func)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_XOR:  alu_op = ALU_XOR;
          FN_SLT:  alu_op = ALU_SLT;
          default: alu_op = ALU_ZERO;
        endcase
      end
      OP_ADDI: begin iclass = CL_IMM;    alu_op = ALU_ADD; end
      OP_SLTI: begin iclass = CL_IMM;    alu_op = ALU_SLT; end
      OP_ANDI: begin iclass = CL_IMM;    alu_op = ALU_AND; end
      OP_ORI:  begin iclass = CL_IMM;    alu_op = ALU_OR;  end
      OP_XORI: begin iclass = CL_IMM;    alu_op = ALU_XOR; end
      OP_LW:   begin iclass = CL_LOAD;   alu_op = ALU_ADD; end
      OP_SW:   begin iclass = CL_STORE;  alu_op = ALU_ADD; end
      OP_BEQZ: begin iclass = CL_BRANCH; alu_op = ALU_ADD; end
      default: begin iclass = CL_NOP;    alu_op = ALU_ADD; end
    endcase
  end
endmodule

// File: rtl/mcyc_alu.sv
`timescale 1ns/1ps
module mcyc_alu
  import mcyc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mcyc_regfile.sv
`timescale 1ns/1ps
module mcyc_regfile
  import mcyc_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREG
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] raddr_a,
  input  logic [$clog2(N)-1:0] raddr_b,
  output logic [W-1:0]         rdata_a,
  output logic [W-1:0]         rdata_b
);
  localparam int RA = $clog2(N);

  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk) begin
    if (we && (waddr != RA'(0))) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == RA'(0)) ? '0 : regs_q[raddr_a];
  assign rdata_b = (raddr_b == RA'(0)) ? '0 : regs_q[raddr_b];

  always_comb begin
    assert_zero_reg_port_a_R10: assert (!(raddr_a == RA'(0) && rdata_a != '0));
  end
endmodule

// File: rtl/mcyc_seq.sv
`timescale 1ns/1ps
module mcyc_seq
  import mcyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iclass_e iclass,
  output step_e   step
);
  step_e step_q, step_d;
  logic  retire_at_mem;

  assign retire_at_mem = (iclass == CL_STORE) || (iclass == CL_BRANCH) ||
                         (iclass == CL_NOP);

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_IF:   step_d = ST_ID;
      ST_ID:   step_d = ST_EX;
      ST_EX:   step_d = ST_MEM;
      ST_MEM:  step_d = retire_at_mem ? ST_IF : ST_WB;
      ST_WB:   step_d = ST_IF;
      default: step_d = ST_IF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_IF;
    else        step_q <= step_d;
  end

  assign step = step_q;

  assert_short_class_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_MEM && retire_at_mem) |=> (step_q == ST_IF));
  assert_long_class_writes_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_MEM && !retire_at_mem) |=> (step_q == ST_WB));
  assert_fetch_then_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_IF) |=> (step_q == ST_ID));
endmodule

// File: rtl/mcyc_core.sv
`timescale 1ns/1ps
module mcyc_core
  import mcyc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          mem_we,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   dbg_pc,
  output logic [2:0]    dbg_state
);
  localparam int W = XLEN;
  localparam logic [W-1:0] STEP4 = W'(4);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  step_e        step;
  iclass_e      iclass;
  alu_op_e      dec_op, alu_op;
  logic [4:0]   rs1, rs2, rd_rr, wb_dst;
  logic [W-1:0] imm_ext, rf_a, rf_b, alu_x, alu_y, alu_r, wb_data, pc_d;
  logic [W-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;
  logic         cond_q, rf_we;
  logic         en_if, en_id, en_ex, en_mem_ld, en_pc;

  mcyc_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .iclass (iclass),
    .step   (step)
  );

  mcyc_decode #(.W(W)) u_dec (
    .ir      (ir_q),
    .iclass  (iclass),
    .alu_op  (dec_op),
    .rs1     (rs1),
    .rs2     (rs2),
    .rd_rr   (rd_rr),
    .imm_ext (imm_ext)
  );

  mcyc_regfile #(.W(W), .N(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (wb_dst),
    .wdata   (wb_data),
    .raddr_a (rs1),
    .raddr_b (rs2),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  // execute operand selection
  assign alu_x  = (iclass == CL_BRANCH) ? npc_q : a_q;
  assign alu_y  = (iclass == CL_RR) ? b_q : imm_q;
  assign alu_op = dec_op;

  mcyc_alu #(.W(W)) u_alu (
    .a  (alu_x),
    .b  (alu_y),
    .op (alu_op),
    .y  (alu_r)
  );

  // clock enables
  assign en_if     = (step == ST_IF);
  assign en_id     = (step == ST_ID);
  assign en_ex     = (step == ST_EX);
  assign en_mem_ld = (step == ST_MEM) && (iclass == CL_LOAD);
  assign en_pc     = ((step == ST_MEM) && ((iclass == CL_STORE) ||
                      (iclass == CL_BRANCH) || (iclass == CL_NOP))) ||
                     (step == ST_WB);

  always_comb begin
    pc_d = npc_q;
    if (step == ST_MEM && iclass == CL_BRANCH && cond_q) pc_d = alu_q;
  end

  // write-back path
  assign rf_we   = (step == ST_WB);
  assign wb_dst  = (iclass == CL_RR) ? rd_rr : rs2;
  assign wb_data = (iclass == CL_LOAD) ? lmd_q : alu_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q   <= '0;
      npc_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      alu_q  <= '0;
      lmd_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      if (en_if) begin
        ir_q  <= mem_rdata;
        npc_q <= pc_q + STEP4;
      end
      if (en_id) begin
        a_q   <= rf_a;
        b_q   <= rf_b;
        imm_q <= imm_ext;
      end
      if (en_ex) begin
        alu_q  <= alu_r;
        cond_q <= (a_q == '0);
      end
      if (en_mem_ld) lmd_q <= mem_rdata;
      if (en_pc)     pc_q  <= pc_d;
    end
  end

  // shared memory port
  assign mem_addr  = (step == ST_MEM) ? alu_q[AW+1:2] : pc_q[AW+1:2];
  assign mem_we    = (step == ST_MEM) && (iclass == CL_STORE);
  assign mem_wdata = b_q;

  assign dbg_pc    = pc_q;
  assign dbg_state = step;

  logic unused_hi;
  assign unused_hi = ^{pc_q[1:0], pc_q[W-1:AW+2], alu_q[1:0], alu_q[W-1:AW+2]};

  assert_npc_follows_pc_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step == ST_IF) |=> (npc_q == $past(pc_q) + STEP4));
  assert_pc_held_midway_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step == ST_IF || step == ST_ID || step == ST_EX) |=> $stable(pc_q));
  assert_pc_after_writeback_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step == ST_WB) |=> (pc_q == $past(npc_q)));
  assert_branch_target_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step == ST_MEM && iclass == CL_BRANCH) |=>
      (pc_q == ($past(cond_q) ? $past(alu_q) : $past(npc_q))));
  assert_store_only_in_mem_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we |-> (step == ST_MEM && mem_addr == alu_q[AW+1:2]));
  assert_zero_operand_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step == ST_ID && rs1 == 5'd0) |=> (a_q == '0));
  assert_nop_no_write_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (iclass == CL_NOP) |-> (!mem_we && !rf_we));
endmodule

// File: tb/sim_mcyc_core.sv
`timescale 1ns/1ps
module sim_mcyc_core;
  logic        clk;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_we;
  logic [31:0] mem_rdata;
  logic [31:0] dbg_pc;
  logic [2:0]  dbg_state;

  int n_chk = 0;
  int n_bad = 0;
  logic started = 1'b0;
  int cnt [64];

  logic [31:0] mem [256];

  // expected contents of data words 64..79
  localparam logic [31:0] EXP [16] = '{
    32'h0000_0005, 32'h0000_0002, 32'h0000_0008, 32'h0000_0005,
    32'hFFFF_FFFD, 32'hFFFF_FFF8, 32'h0000_0001, 32'h0000_0000,
    32'h0000_0069, 32'h0000_0000, 32'hDEAD_000A, 32'h0000_0005,
    32'hFFFF_FFFD, 32'h0000_00F5, 32'h0000_0001, 32'h0000_0005
  };

  mcyc_core #(.AW(16)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .dbg_pc    (dbg_pc),
    .dbg_state (dbg_state)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 8 ns period

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  always @(negedge clk) if (started) cnt[dbg_pc[7:2]] = cnt[dbg_pc[7:2]] + 1;

  function automatic logic [31:0] ei(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] er(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic string tag_of(int i);
    case (i)
      0: return "R7";
      8: return "R6";
      9: return "R10";
      10, 11: return "R8";
      12: return "R11";
      13, 14: return "R5";
      15: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) cnt[i] = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 16; i++) mem[64 + i] = 32'hDEAD_0000 + 32'(i);
    mem[0]  = ei(6'h08, 0, 1, 16'd5);
    mem[1]  = ei(6'h08, 0, 2, 16'hFFFD);
    mem[2]  = ei(6'h2B, 0, 1, 16'd256);
    mem[3]  = er(1, 2, 3, 6'h20);
    mem[4]  = ei(6'h2B, 0, 3, 16'd260);
    mem[5]  = er(1, 2, 4, 6'h22);
    mem[6]  = ei(6'h2B, 0, 4, 16'd264);
    mem[7]  = er(1, 2, 5, 6'h24);
    mem[8]  = ei(6'h2B, 0, 5, 16'd268);
    mem[9]  = er(1, 2, 6, 6'h25);
    mem[10] = ei(6'h2B, 0, 6, 16'd272);
    mem[11] = er(1, 2, 7, 6'h26);
    mem[12] = ei(6'h2B, 0, 7, 16'd276);
    mem[13] = er(2, 1, 8, 6'h2A);
    mem[14] = ei(6'h2B, 0, 8, 16'd280);
    mem[15] = er(1, 2, 9, 6'h2A);
    mem[16] = ei(6'h2B, 0, 9, 16'd284);
    mem[17] = ei(6'h23, 0, 10, 16'd256);
    mem[18] = ei(6'h08, 10, 10, 16'd100);
    mem[19] = ei(6'h2B, 0, 10, 16'd288);
    mem[20] = ei(6'h08, 0, 0, 16'd7);
    mem[21] = ei(6'h2B, 0, 0, 16'd292);
    mem[22] = ei(6'h04, 0, 0, 16'd8);
    mem[23] = ei(6'h2B, 0, 1, 16'd296);
    mem[24] = ei(6'h08, 0, 1, 16'd99);
    mem[25] = ei(6'h04, 1, 0, 16'd4);
    mem[26] = ei(6'h2B, 0, 1, 16'd300);
    mem[27] = ei(6'h3F, 0, 1, 16'd304);
    mem[28] = ei(6'h2B, 0, 2, 16'd304);
    mem[29] = ei(6'h08, 0, 13, 16'd320);
    mem[30] = ei(6'h2B, 13, 1, 16'hFFFC);
    mem[31] = ei(6'h0E, 1, 14, 16'h00F0);
    mem[32] = ei(6'h2B, 0, 14, 16'd308);
    mem[33] = ei(6'h0A, 2, 15, 16'hFFFE);
    mem[34] = ei(6'h2B, 0, 15, 16'd312);
    mem[35] = ei(6'h04, 0, 0, 16'hFFFC);

    repeat (3) @(negedge clk);
    chk("R1 pc in reset", dbg_pc, 32'd0);
    chk("R1 step in reset", {29'd0, dbg_state}, 32'd0);

    rst_n = 1'b1;
    started = 1'b1;
    repeat (2) @(negedge clk);
    // synchroniser released: step sequence of the first ADDI
    for (int k = 0; k < 5; k++) begin
      chk("R9 step order", {29'd0, dbg_state}, 32'(k));
      @(negedge clk);
    end
    chk("R2 pc after first instr", dbg_pc, 32'd4);

    repeat (400) @(negedge clk);

    // vector table walk: data words 64..79
    for (int i = 0; i < 16; i++) chk(tag_of(i), mem[64 + i], EXP[i]);

    // directed cycle counts per instruction word
    chk("R9 addi cycles",  32'(cnt[1]),  32'd5);
    chk("R9 store cycles", 32'(cnt[2]),  32'd4);
    chk("R9 rr cycles",    32'(cnt[3]),  32'd5);
    chk("R9 load cycles",  32'(cnt[17]), 32'd5);
    chk("R8 taken branch cycles", 32'(cnt[22]), 32'd4);
    chk("R8 skipped word 23", 32'(cnt[23]), 32'd0);
    chk("R8 skipped word 24", 32'(cnt[24]), 32'd0);
    chk("R8 not-taken branch cycles", 32'(cnt[25]), 32'd4);
    chk("R11 undefined cycles", 32'(cnt[27]), 32'd4);
    chk("R2 fetch after undefined", 32'(cnt[28]), 32'd4);
    chk("R8 halt loop pc", dbg_pc, 32'd140);

    // asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 pc after async reset", dbg_pc, 32'd0);
    chk("R1 step after async reset", {29'd0, dbg_state}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule